// File: doc/BRIEF.md
# Low-Power Supply Watchdog and Overcurrent Timer

This block is active while the chip sits in the low-power state where the main supply rail stays on and the microcontroller remains powered. It watches a comparator flag that reports the supply output current above a small threshold. It measures how long the flag stays high, counting a 1 ms tick against a selectable window. A burst that ends inside the window is taken as the microcontroller doing a short, permitted piece of work. Such a burst refreshes the watchdog and does not wake the system. A burst that outlasts the window raises a wake request.

The watchdog is optional and works as a plain timeout. Once enabled, it counts ticks against a selectable period. A dedicated refresh strobe or a short overcurrent burst restarts the count. If the period runs out without a refresh, the block emits a single-cycle timeout pulse and holds its count until the next refresh. As long as refreshes keep coming, neither a wake nor a timeout is produced.

The overcurrent side is a state machine with the states OC_IDLE, OC_TIMING and OC_HELD, and the following transitions:
- start: OC_IDLE to OC_TIMING, when the flag is first seen high.
- short burst: OC_TIMING to OC_IDLE, when the flag drops inside the window.
- expire: OC_TIMING to OC_HELD, when the window runs out with the flag high.
- release: OC_HELD to OC_IDLE, when the flag drops.

The watchdog side is a state machine with the states WD_OFF, WD_RUN and WD_EXPIRED, and the following transitions:
- arm: WD_OFF to WD_RUN, when the enable is seen high.
- expire: WD_RUN to WD_EXPIRED, when the period runs out.
- rearm: WD_EXPIRED to WD_RUN, on a refresh.
- disarm: any state to WD_OFF, when the enable is low.

Top module: `lp_wdog_ocp`

## Requirements
- R1: After reset both `wake_req` and `wd_timeout` are low.
- R2: The overcurrent timer starts on the clock edge where `oc_flag` is first seen high. A tick on that same edge is not counted. With `oc_win_sel` equal to 0, 1, 2 or 3, the window is 4, 8, 16 or 32 ticks. If the flag is still high on the edge that samples the last tick of the window, `wake_req` is high for one cycle in the cycle after that edge.
- R3: One overcurrent episode gives at most one `wake_req` pulse. After that pulse, further ticks with the flag held give no new pulse. The eventual drop of the flag after that pulse is not a refresh.
- R4: When `oc_flag` drops before the window ends, no wake is raised and the timer clears. The next episode counts its full window from zero.
- R5: A flag drop before the window ends refreshes the watchdog. The refresh happens on the edge where the low flag is sampled.
- R6: A high `refresh_cmd` restarts the watchdog count and never causes `wake_req`. While refreshes keep coming within the period, `wd_timeout` stays low.
- R7: With the watchdog enabled, `wd_per_sel` equal to 0, 1, 2 or 3 selects a period of 64, 128, 256 or 512 ticks. With no refresh, `wd_timeout` is high for one cycle in the cycle after the edge that samples the last tick of the period.
- R8: After a timeout the watchdog count stops: further ticks give no further pulse. A refresh restarts a full period.
- R9: While `wd_enable` is low, no timeout is produced and the count is cleared. After re-enabling, a full period is needed before a timeout.
- R10: A refresh sampled on the same edge as the tick that would end the period wins. No timeout is produced, and the count restarts from zero.
- R11: A flag drop sampled on the same edge as the tick that would end the overcurrent window counts as a short burst. It raises no wake, and it refreshes the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle strobe once per millisecond |
| oc_flag | input | 1 | Supply current above threshold |
| oc_win_sel | input | 2 | Overcurrent window code |
| wd_enable | input | 1 | Watchdog enable |
| wd_per_sel | input | 2 | Watchdog period code |
| refresh_cmd | input | 1 | One-cycle dedicated refresh strobe |
| wake_req | output | 1 | One-cycle wake request pulse |
| wd_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two pairs of events can land on the same edge. The first pair is a refresh and the tick that would end the watchdog period. The second pair is a flag drop and the tick that would end the overcurrent window. The bench provokes each pair by counting exactly one tick short of the limit. It then drives the refresh strobe (or drops the flag) together with the final tick. The collision is judged by the absence of any pulse on that edge. It is also judged by a timeout that appears exactly one full period of ticks later, which shows that the count restarted from zero.

// File: rtl/lpwd_pkg.sv
package lpwd_pkg;

    typedef enum logic [1:0] {
        OC_IDLE   = 2'd0,
        OC_TIMING = 2'd1,
        OC_HELD   = 2'd2
    } oc_state_e;

    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_RUN     = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/lpwd_limit.sv
// Turns a 2-bit code into a tick limit of BASE shifted left by the code.
module lpwd_limit #(
    parameter int BASE = 4,
    parameter int CW   = $clog2(BASE * 8 + 1)
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] limit
);
    localparam logic [CW-1:0] BASE_V = CW'(BASE);

    always_comb begin
        limit = BASE_V << sel;
    end
endmodule

// File: rtl/lpwd_oc_timer.sv
module lpwd_oc_timer
    import lpwd_pkg::*;
#(
    parameter int MIN_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       oc_flag,
    input  logic [1:0] win_sel,
    output logic       burst_refresh,
    output logic       wake_req
);
    localparam int CW = $clog2(MIN_TICKS * 8 + 1);

    oc_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          last_tick;
    logic          wake_q;

    lpwd_limit #(.BASE(MIN_TICKS), .CW(CW)) u_lim (
        .sel   (win_sel),
        .limit (limit)
    );

    assign last_tick = tick && (cnt_q >= limit - CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OC_IDLE:   if (oc_flag) state_d = OC_TIMING;
            OC_TIMING: begin
                if (!oc_flag)       state_d = OC_IDLE;   // short burst
                else if (last_tick) state_d = OC_HELD;   // expire
            end
            OC_HELD:   if (!oc_flag) state_d = OC_IDLE;  // release
            default:   state_d = OC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            wake_q <= (state_q == OC_TIMING) && (state_d == OC_HELD);
            if (state_q == OC_TIMING && state_d == OC_TIMING && tick)
                cnt_q <= cnt_q + CW'(1);
            else if (state_d != OC_TIMING)
                cnt_q <= '0;
        end
    end

    assign burst_refresh = (state_q == OC_TIMING) && !oc_flag;
    assign wake_req      = wake_q;
endmodule

// File: rtl/lpwd_wd_timer.sv
module lpwd_wd_timer
    import lpwd_pkg::*;
#(
    parameter int MIN_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       refresh,
    input  logic [1:0] per_sel,
    output logic       timeout
);
    localparam int CW = $clog2(MIN_TICKS * 8 + 1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          last_tick;
    logic          timeout_q;

    lpwd_limit #(.BASE(MIN_TICKS), .CW(CW)) u_lim (
        .sel   (per_sel),
        .limit (limit)
    );

    assign last_tick = tick && (cnt_q >= limit - CW'(1));

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = WD_OFF;                               // disarm
        end else begin
            unique case (state_q)
                WD_OFF:     state_d = WD_RUN;               // arm
                WD_RUN:     if (!refresh && last_tick) state_d = WD_EXPIRED;
                WD_EXPIRED: if (refresh) state_d = WD_RUN;  // rearm
                default:    state_d = WD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= (state_q == WD_RUN) && (state_d == WD_EXPIRED);
            if (state_q == WD_RUN && state_d == WD_RUN && !refresh && tick)
                cnt_q <= cnt_q + CW'(1);
            else if (state_q != WD_RUN || state_d != WD_RUN || refresh)
                cnt_q <= '0;
        end
    end

    assign timeout = timeout_q;
endmodule

// File: rtl/lp_wdog_ocp.sv
module lp_wdog_ocp #(
    parameter int OC_MIN_TICKS = 4,
    parameter int WD_MIN_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       oc_flag,
    input  logic [1:0] oc_win_sel,
    input  logic       wd_enable,
    input  logic [1:0] wd_per_sel,
    input  logic       refresh_cmd,
    output logic       wake_req,
    output logic       wd_timeout
);
    logic burst_refresh;
    logic any_refresh;

    lpwd_oc_timer #(.MIN_TICKS(OC_MIN_TICKS)) u_oc (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick_1ms),
        .oc_flag       (oc_flag),
        .win_sel       (oc_win_sel),
        .burst_refresh (burst_refresh),
        .wake_req      (wake_req)
    );

    assign any_refresh = refresh_cmd | burst_refresh;

    lpwd_wd_timer #(.MIN_TICKS(WD_MIN_TICKS)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1ms),
        .enable  (wd_enable),
        .refresh (any_refresh),
        .per_sel (wd_per_sel),
        .timeout (wd_timeout)
    );
endmodule

// File: rtl/lpwd_checker.sv
module lpwd_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_1ms,
    input logic oc_flag,
    input logic wd_enable,
    input logic refresh_cmd,
    input logic wake_req,
    input logic wd_timeout
);
    a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    a_r2_wake_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(tick_1ms) && $past(oc_flag)));

    a_r4_no_wake_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_flag |=> !wake_req);

    a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !wd_timeout);

    a_r7_timeout_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> $past(tick_1ms));

    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_enable |=> !wd_timeout);

    a_r10_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_cmd |=> !wd_timeout);
endmodule

bind lp_wdog_ocp lpwd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_1ms    (tick_1ms),
    .oc_flag     (oc_flag),
    .wd_enable   (wd_enable),
    .refresh_cmd (refresh_cmd),
    .wake_req    (wake_req),
    .wd_timeout  (wd_timeout)
);

// File: tb/lp_wdog_ocp_tb.sv
module lp_wdog_ocp_tb;
    localparam bit K_WAKE = 1'b0;
    localparam bit K_TO   = 1'b1;

    typedef struct {
        bit    kind;
        int    cyc;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       oc_flag = 1'b0;
    logic [1:0] oc_win_sel = 2'd0;
    logic       wd_enable = 1'b0;
    logic [1:0] wd_per_sel = 2'd0;
    logic       refresh_cmd = 1'b0;
    logic       wake_req;
    logic       wd_timeout;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    lp_wdog_ocp u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_1ms    (tick_1ms),
        .oc_flag     (oc_flag),
        .oc_win_sel  (oc_win_sel),
        .wd_enable   (wd_enable),
        .wd_per_sel  (wd_per_sel),
        .refresh_cmd (refresh_cmd),
        .wake_req    (wake_req),
        .wd_timeout  (wd_timeout)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Monitor: every output pulse must match the head of the scoreboard.
    task automatic judge(bit kind);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, kind ? "R7" : "R2", kind ? "unexpected timeout at cycle" : "unexpected wake at cycle",
                  cyc, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind && e.cyc == cyc, e.tag,
                  e.kind ? "timeout pulse cycle" : "wake pulse cycle",
                  (e.kind == kind) ? cyc : -cyc, e.cyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wake_req)   judge(K_WAKE);
            if (wd_timeout) judge(K_TO);
        end
    end

    // Driver tasks
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk); tick_1ms = 1'b1;
            @(negedge clk); tick_1ms = 1'b0;
        end
    endtask

    task automatic tick_expect(bit kind, string tag);
        exp_t e;
        @(negedge clk);
        tick_1ms = 1'b1;
        e.kind = kind; e.cyc = cyc + 1; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        tick_1ms = 1'b0;
    endtask

    task automatic refresh();
        @(negedge clk); refresh_cmd = 1'b1;
        @(negedge clk); refresh_cmd = 1'b0;
    endtask

    task automatic set_flag(bit v);
        @(negedge clk); oc_flag = v;
    endtask

    task automatic drain(string tag);
        idle(2);
        check(sb.size() == 0, tag, "pending expected pulses", sb.size(), 0);
        sb.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check(wake_req == 1'b0,   "R1", "wake_req after reset",   wake_req,   0);
        check(wd_timeout == 1'b0, "R1", "wd_timeout after reset", wd_timeout, 0);

        // R2 / R3: each window code, wake at the last tick; held flag gives nothing more
        for (int s = 0; s < 4; s++) begin
            oc_win_sel = 2'(s);
            set_flag(1'b1);
            idle(1);
            ticks((4 << s) - 1);
            tick_expect(K_WAKE, "R2");
            drain("R2");
            ticks(10);
            set_flag(1'b0);
            drain("R3");
        end

        // R4: short burst then a full fresh window
        oc_win_sel = 2'd0;
        set_flag(1'b1); idle(1); ticks(3);
        set_flag(1'b0); idle(2);
        drain("R4");
        set_flag(1'b1); idle(1); ticks(3);
        tick_expect(K_WAKE, "R4");
        set_flag(1'b0);
        drain("R4");

        // R7 / R8: watchdog period codes, stop after expiry, restart on refresh
        @(negedge clk); wd_enable = 1'b1; wd_per_sel = 2'd0;
        idle(2);
        ticks(63);
        tick_expect(K_TO, "R7");
        drain("R7");
        ticks(100);
        drain("R8");
        refresh();
        ticks(63);
        tick_expect(K_TO, "R8");
        drain("R8");
        for (int s = 1; s < 4; s++) begin
            wd_per_sel = 2'(s);
            refresh();
            ticks((64 << s) - 1);
            tick_expect(K_TO, "R7");
            drain("R7");
        end
        wd_per_sel = 2'd0;

        // R6: regular refreshes hold off the timeout, no wake
        refresh();
        repeat (6) begin
            ticks(50);
            refresh();
        end
        drain("R6");
        ticks(63);
        tick_expect(K_TO, "R6");
        drain("R6");

        // R5: a short overcurrent burst refreshes the watchdog
        refresh();
        ticks(60);
        set_flag(1'b1); idle(1); ticks(2);
        set_flag(1'b0); idle(1);
        ticks(63);
        drain("R5");
        tick_expect(K_TO, "R5");
        drain("R5");

        // R9: disable clears and silences the watchdog
        refresh();
        ticks(40);
        @(negedge clk); wd_enable = 1'b0;
        ticks(100);
        drain("R9");
        @(negedge clk); wd_enable = 1'b1;
        idle(2);
        ticks(63);
        drain("R9");
        tick_expect(K_TO, "R9");
        drain("R9");

        // R10: refresh on the same edge as the expiring tick
        refresh();
        ticks(63);
        @(negedge clk); tick_1ms = 1'b1; refresh_cmd = 1'b1;
        @(negedge clk); tick_1ms = 1'b0; refresh_cmd = 1'b0;
        drain("R10");
        ticks(63);
        tick_expect(K_TO, "R10");
        drain("R10");

        // R11: flag drop on the same edge as the window-ending tick
        refresh();
        ticks(30);
        oc_win_sel = 2'd0;
        set_flag(1'b1); idle(1); ticks(3);
        @(negedge clk); oc_flag = 1'b0; tick_1ms = 1'b1;
        @(negedge clk); tick_1ms = 1'b0;
        drain("R11");
        ticks(63);
        drain("R11");
        tick_expect(K_TO, "R11");
        drain("R11");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule